// File: doc/BRIEF.md
# Multichannel Receive Signal-Detect and Squelch Controller

This block is the digital control for a twelve-lane optical receiver. Each lane delivers a raw loss-of-signal flag from its analog level detector. The block filters every flag on its own, with separate qualification counters for the arrival and the departure of signal. It then reports one module-wide signal-detect output, which is high only when every lane holds a qualified signal.

For each lane the block also produces a two-bit gating code that tells the lane's output buffer what to do: pass data, squelch it, or drive a static high. Three active-high control pins modify the result. Output enable forces every lane high. Squelch enable allows lanes without signal to be muted. Detect enable, when low, forces the module signal-detect output high.

Squelching always follows the qualified per-lane detect and never the forced module output. A system can therefore mask the module status and still keep dead lanes quiet. Both qualification windows are given in clock cycles. With a 50 MHz clock, the defaults correspond to roughly 170 µs for arrival and 190 µs for departure.

Top module: `rxdet_squelch_ctrl`

## Requirements
- R1: While reset is held, and on the first cycles after it, `sig_detect` is 0, every lane's qualified detect is cleared, and every lane code reads 01 (squelched).
- R2: A lane's qualified detect rises only after its `chan_los` bit has been sampled low on ON_CYC consecutive rising edges. A low period that is even one edge shorter has no effect on any output.
- R3: A lane's qualified detect falls only after its `chan_los` bit has been sampled high on OFF_CYC consecutive rising edges. A shorter high period has no effect on any output.
- R4: With `detect_en` high, `sig_detect` is the AND of all qualified lane detects, registered one cycle after they change. A loss on any single lane, including the highest-numbered lane, drives it low.
- R5: While `detect_en` is low, `sig_detect` is 1 from the next cycle, whatever the lane states are.
- R6: With `out_en` high and `squelch_en` high, a lane without a qualified detect reads code 01 (squelched), and a lane with one reads 00 (pass).
- R7: With `out_en` high and `squelch_en` low, every lane reads 00 (pass), whatever its signal state.
- R8: With `out_en` low, every lane reads 10 (static high) from the next cycle. This takes priority over squelch.
- R9: Holding `detect_en` low does not change any lane code. Squelch decisions use the qualified per-lane detect.
- R10: Lane i's code sits at bits [2i+1:2i] of `lane_mode`. Code 11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_los | input | NUM_CH | Raw per-lane loss-of-signal, 1 = no signal |
| out_en | input | 1 | Output enable, active high. Low forces every lane high |
| squelch_en | input | 1 | Squelch enable, active high |
| detect_en | input | 1 | Signal-detect enable, active high. Low forces `sig_detect` high |
| sig_detect | output | 1 | Module signal detect, high when all lanes are qualified |
| lane_mode | output | 2*NUM_CH | Per-lane gating codes: 00 pass, 01 squelch, 10 force high |

## Verification
A change on a control pin appears on the outputs one rising edge later. A lane loss or restore that is first seen on edge k moves the lane's qualified detect at edge k+N−1, where N is that direction's window, and reaches the outputs at edge k+N. The bench schedules every expected result against its absolute cycle number at the moment it applies the stimulus. It compares on falling edges, both one cycle before the due edge, to show that nothing changed early, and on the due edge itself. Glitches one edge shorter than a window are checked for silence at and after the cycle where a full window would have acted.

// File: rtl/rxdet_pkg.sv
`timescale 1ns/1ps
package rxdet_pkg;

   // Per-lane output gating code; bit placement is lane i -> [2i+1:2i]
   typedef enum logic [1:0] {
      LANE_PASS = 2'b00,
      LANE_MUTE = 2'b01,
      LANE_HIGH = 2'b10
   } lane_mode_e;

   // Priority: output enable, then squelch, then pass
   function automatic lane_mode_e pick_mode(input logic oe,
                                            input logic sq,
                                            input logic ok);
      lane_mode_e m;
      if (!oe)
         m = LANE_HIGH;
      else if (sq && !ok)
         m = LANE_MUTE;
      else
         m = LANE_PASS;
      return m;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rxdet_lane_filter.sv
`timescale 1ns/1ps
module rxdet_lane_filter #(
   parameter int ON_CYC  = 8500,
   parameter int OFF_CYC = 9500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic los_i,
   output logic ok_o
);
   import rxdet_pkg::*;

   localparam int MAX_WIN = max_int(ON_CYC, OFF_CYC);
   localparam int CW      = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
   localparam bit NO_CNT  = (ON_CYC == 1) && (OFF_CYC == 1);

   initial begin
      assert (ON_CYC >= 1)  else $error("rxdet_lane_filter: ON_CYC must be at least 1");
      assert (OFF_CYC >= 1) else $error("rxdet_lane_filter: OFF_CYC must be at least 1");
   end

   logic raw_ok;
   logic ok_q;

   assign raw_ok = ~los_i;
   assign ok_o   = ok_q;

   generate
      if (NO_CNT) begin : g_direct
         // Single-cycle windows: qualification degenerates to one register
         always_ff @(posedge clk) begin
            if (!rst_n)
               ok_q <= 1'b0;
            else
               ok_q <= raw_ok;
         end
      end else begin : g_counted
         localparam logic [CW-1:0] ON_LIM  = CW'(ON_CYC - 1);
         localparam logic [CW-1:0] OFF_LIM = CW'(OFF_CYC - 1);

         logic [CW-1:0] run_q;
         logic [CW-1:0] lim;
         logic          differ;

         assign differ = raw_ok ^ ok_q;
         assign lim    = ok_q ? OFF_LIM : ON_LIM;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ok_q  <= 1'b0;
               run_q <= '0;
            end else if (!differ) begin
               run_q <= '0;
            end else if (run_q == lim) begin
               ok_q  <= raw_ok;
               run_q <= '0;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         // R2/R3: the run counter never passes the longer window
         assert_run_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
            run_q <= CW'(MAX_WIN - 1));
      end
   endgenerate

   // R2: qualified detect rises only on an edge that saw signal present
   assert_rise_on_signal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok_q) |-> $past(raw_ok));

   // R3: qualified detect falls only on an edge that saw the loss flag
   assert_fall_on_loss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ok_q) |-> !$past(raw_ok));

endmodule

// File: rtl/rxdet_lane_gate.sv
`timescale 1ns/1ps
module rxdet_lane_gate
   import rxdet_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       oe_i,
   input  logic       sq_i,
   input  logic       ok_i,
   output lane_mode_e mode_o
);

   lane_mode_e mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         mode_q <= LANE_MUTE;
      else
         mode_q <= pick_mode(oe_i, sq_i, ok_i);
   end

   assign mode_o = mode_q;

   assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_i |=> (mode_q == LANE_HIGH));

   assert_squelch_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_i && !sq_i) |=> (mode_q == LANE_PASS));

   assert_dead_lane_muted_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_i && sq_i && !ok_i) |=> (mode_q == LANE_MUTE));

   assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q != lane_mode_e'(2'b11));

endmodule

// File: rtl/rxdet_detect_merge.sv
`timescale 1ns/1ps
module rxdet_detect_merge #(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ok_i,
   input  logic              det_en_i,
   output logic              sd_o
);

   initial begin
      assert (NUM_CH >= 1) else $error("rxdet_detect_merge: NUM_CH must be at least 1");
   end

   logic all_ok;
   logic sd_q;

   assign all_ok = &ok_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sd_q <= 1'b0;
      else
         sd_q <= all_ok | ~det_en_i;
   end

   assign sd_o = sd_q;

   assert_forced_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !det_en_i |=> sd_q);

   assert_any_loss_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en_i && !(&ok_i)) |=> !sd_q);

   assert_all_ok_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (det_en_i && (&ok_i)) |=> sd_q);

endmodule

// File: rtl/rxdet_squelch_ctrl.sv
`timescale 1ns/1ps
module rxdet_squelch_ctrl
   import rxdet_pkg::*;
#(
   parameter int NUM_CH  = 12,
   parameter int ON_CYC  = 8500,
   parameter int OFF_CYC = 9500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CH-1:0]   chan_los,
   input  logic                out_en,
   input  logic                squelch_en,
   input  logic                detect_en,
   output logic                sig_detect,
   output logic [2*NUM_CH-1:0] lane_mode
);

   localparam int MODE_W = 2;

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 256)
         else $error("rxdet_squelch_ctrl: NUM_CH out of range");
      assert ($bits(lane_mode_e) == MODE_W)
         else $error("rxdet_squelch_ctrl: lane code width mismatch");
   end

   logic [NUM_CH-1:0] lane_ok;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
         lane_mode_e mode_w;

         rxdet_lane_filter #(
            .ON_CYC  (ON_CYC),
            .OFF_CYC (OFF_CYC)
         ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .los_i (chan_los[i]),
            .ok_o  (lane_ok[i])
         );

         rxdet_lane_gate u_gate (
            .clk    (clk),
            .rst_n  (rst_n),
            .oe_i   (out_en),
            .sq_i   (squelch_en),
            .ok_i   (lane_ok[i]),
            .mode_o (mode_w)
         );

         assign lane_mode[MODE_W*i +: MODE_W] = mode_w;

         // R9: masking the module detect leaves squelch decisions intact
         assert_mask_keeps_squelch_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!detect_en && out_en && squelch_en && !lane_ok[i])
               |=> (lane_mode[MODE_W*i +: MODE_W] == 2'b01));
      end
   endgenerate

   rxdet_detect_merge #(
      .NUM_CH (NUM_CH)
   ) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .ok_i     (lane_ok),
      .det_en_i (detect_en),
      .sd_o     (sig_detect)
   );

endmodule

// File: tb/sim_rxdet_squelch_ctrl.sv
`timescale 1ns/1ps
module sim_rxdet_squelch_ctrl;

   localparam int NCH = 12;
   localparam int ONW = 6;
   localparam int OFW = 4;

   typedef struct {
      int              due;
      logic            sd;
      logic [2*NCH-1:0] mode;
      string           tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   los = '1;
   logic             oe = 1'b1;
   logic             sq = 1'b1;
   logic             de = 1'b1;
   logic             sd_w;
   logic [2*NCH-1:0] mode_w;

   int   cyc = 0;
   int   checks = 0;
   int   failures = 0;
   bit   finished = 1'b0;
   exp_t sb_q[$];
   exp_t keep_q[$];

   always #10 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   rxdet_squelch_ctrl #(
      .NUM_CH  (NCH),
      .ON_CYC  (ONW),
      .OFF_CYC (OFW)
   ) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_los   (los),
      .out_en     (oe),
      .squelch_en (sq),
      .detect_en  (de),
      .sig_detect (sd_w),
      .lane_mode  (mode_w)
   );

   // Expected lane codes from R6/R7/R8/R10: 00 pass, 01 squelch, 10 high
   function automatic logic [2*NCH-1:0] mk_mode(input logic [NCH-1:0] lost,
                                               input logic s, input logic o);
      logic [2*NCH-1:0] v;
      for (int i = 0; i < NCH; i++) begin
         if (!o)                 v[2*i +: 2] = 2'b10;
         else if (s && lost[i])  v[2*i +: 2] = 2'b01;
         else                    v[2*i +: 2] = 2'b00;
      end
      return v;
   endfunction

   task automatic expect_in(input int k, input logic esd, input logic [NCH-1:0] lost,
                            input logic s, input logic o, input string tag);
      exp_t e;
      e.due  = cyc + k;
      e.sd   = esd;
      e.mode = mk_mode(lost, s, o);
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   task automatic compare(input string tag, input logic esd, input logic [2*NCH-1:0] emode);
      checks++;
      if (sd_w !== esd || mode_w !== emode) begin
         failures++;
         $display("FAIL %s cyc=%0d sig_detect=%b expected=%b lane_mode=%h expected=%h",
                  tag, cyc, sd_w, esd, mode_w, emode);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Monitor: pops every item due in this cycle, between rising edges
   always @(negedge clk) begin
      for (int i = 0; i < sb_q.size(); i++) begin
         if (sb_q[i].due == cyc)
            compare(sb_q[i].tag, sb_q[i].sd, sb_q[i].mode);
         else
            keep_q.push_back(sb_q[i]);
      end
      sb_q = keep_q;
      keep_q.delete();
   end

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      finish_run();
   end

   initial begin
      // R1: reset state
      wait_n(3);
      compare("R1 reset", 1'b0, mk_mode('1, 1'b1, 1'b1));
      rst_n = 1'b1;
      expect_in(2, 1'b0, '1, 1'b1, 1'b1, "R1 after reset");
      wait_n(3);

      // R2/R4: all lanes gain signal; rises ONW+1 cycles later, not before
      @(negedge clk);
      los = '0;
      expect_in(ONW,     1'b0, '1, 1'b1, 1'b1, "R2 not early");
      expect_in(ONW + 1, 1'b1, '0, 1'b1, 1'b1, "R2 R4 all lanes up");
      wait_n(ONW + 3);

      // R3: loss glitch one edge shorter than OFW is ignored
      @(negedge clk);
      los = 12'h008;
      expect_in(OFW + 1, 1'b1, '0, 1'b1, 1'b1, "R3 short loss ignored");
      expect_in(OFW + 3, 1'b1, '0, 1'b1, 1'b1, "R3 short loss later");
      wait_n(OFW - 1);
      los = '0;
      wait_n(6);

      // R3/R4/R6: lane 5 lost for good
      @(negedge clk);
      los = 12'h020;
      expect_in(OFW,     1'b1, '0,     1'b1, 1'b1, "R3 not early");
      expect_in(OFW + 1, 1'b0, 12'h020, 1'b1, 1'b1, "R3 R4 R6 lane5 down");
      wait_n(OFW + 3);

      // R2: restore glitch one edge shorter than ONW is ignored
      @(negedge clk);
      los = '0;
      expect_in(ONW + 1, 1'b0, 12'h020, 1'b1, 1'b1, "R2 short restore ignored");
      wait_n(ONW - 1);
      los = 12'h020;
      wait_n(4);

      // R5/R9: mask module detect; lane 5 stays squelched
      @(negedge clk);
      de = 1'b0;
      expect_in(1, 1'b1, 12'h020, 1'b1, 1'b1, "R5 R9 forced detect");
      wait_n(2);

      // R7: squelch disabled
      @(negedge clk);
      sq = 1'b0;
      expect_in(1, 1'b1, 12'h020, 1'b0, 1'b1, "R7 squelch off");
      wait_n(2);
      sq = 1'b1;
      expect_in(1, 1'b1, 12'h020, 1'b1, 1'b1, "R6 squelch back on");
      wait_n(2);

      // R8: output enable low overrides squelch
      @(negedge clk);
      oe = 1'b0;
      expect_in(1, 1'b1, 12'h020, 1'b1, 1'b0, "R8 force high");
      wait_n(2);
      sq = 1'b0;
      expect_in(1, 1'b1, 12'h020, 1'b0, 1'b0, "R8 force high sq off");
      wait_n(2);
      oe = 1'b1;
      sq = 1'b1;
      expect_in(1, 1'b1, 12'h020, 1'b1, 1'b1, "R8 release");
      wait_n(2);

      // R4/R5: unmask detect
      @(negedge clk);
      de = 1'b1;
      expect_in(1, 1'b0, 12'h020, 1'b1, 1'b1, "R4 R5 unmask");
      wait_n(2);

      // R6/R10: mixed pattern, losses at OFW+1, lane5 restore at ONW+1
      @(negedge clk);
      los = 12'hA53;
      expect_in(OFW + 1, 1'b0, 12'hA73, 1'b1, 1'b1, "R6 R10 mixed losses");
      expect_in(ONW + 1, 1'b0, 12'hA53, 1'b1, 1'b1, "R6 R10 lane5 restored");
      wait_n(ONW + 3);

      // R4: only the top lane missing keeps detect low
      @(negedge clk);
      los = 12'h800;
      expect_in(ONW + 1, 1'b0, 12'h800, 1'b1, 1'b1, "R4 top lane lost");
      wait_n(ONW + 3);
      @(negedge clk);
      los = '0;
      expect_in(ONW + 1, 1'b1, '0, 1'b1, 1'b1, "R4 top lane back");
      wait_n(ONW + 3);

      while (sb_q.size() != 0) @(negedge clk);
      wait_n(1);
      finish_run();
   end

endmodule